// File: doc/BRIEF.md
# Receive Packet Claim and Dispatch

This block sits on the receive side of a packet link. Each beat presented at its input is either a command word or a data word. A command word carries a class code, a request address, a unit identifier, a source tag and the number of data beats that follow it. The block decides whether this node owns the command.

A request is owned when its address lands in one of several enabled address windows. A response is owned when its unit identifier equals the node's own identifier. Owned commands are written to one of three queues: posted, non-posted or response. The data beats that follow a command go wherever the command went.

Traffic the node does not own goes to an end-of-chain handler. For posted requests and responses, the handler raises an error pulse and a sticky error flag. For a non-posted request, it emits a non-existent-address response that carries the request's tag and unit identifier. Data beats that belong to unowned commands are discarded. The window and identifier settings are plain inputs. All outputs are registered and appear one clock after the beat that caused them.

Top module: `rxd_claim_dispatch`

## Requirements
- R1: While reset is held, and on the first cycle after it, all queue write strobes, the error pulse, the sticky error flag and the response-valid output are low.
- R2: The class field `in_ctype` is decoded as 2'b01 posted request, 2'b10 non-posted request, 2'b11 response and 2'b00 no-op. A no-op command writes no queue, raises nothing and leaves the count of outstanding data beats unchanged.
- R3: Window i matches when `bar_en[i]` is set and (addr & mask_i) == (base_i & mask_i). Window i occupies bits [i*ADDR_W +: ADDR_W] of `bar_base` and `bar_mask`. A disabled window never matches.
- R4: A posted request that matches any window pulses `pq_wr`, and a matching non-posted request pulses `npq_wr`. The pulse comes one cycle after the beat, with `q_word` equal to `in_data` and `q_is_cmd` high. At most one queue strobe is high in any cycle.
- R5: A response whose `in_uid` equals `local_uid` pulses `rq_wr` one cycle later, with the same word and flag rules.
- R6: After a command with `in_dlen` = N, the next N data beats (`in_is_cmd` low) are written to the same queue as the command, with `q_is_cmd` low. Idle cycles and no-op commands between them do not disturb this.
- R7: An unclaimed posted request or an unclaimed response gives a one-cycle `err_pulse` and sets `err_sticky` one cycle after the beat. The flag stays set until a cycle with `err_clr` high and no new error. A new error in the same cycle as a clear wins.
- R8: An unclaimed non-posted request gives a one-cycle `nxa_valid` with `nxa_tag` and `nxa_uid` copied from the request. It writes no queue and raises no error.
- R9: Data beats of an unclaimed command, and data beats that arrive while no beats are outstanding, write no queue and raise no error or response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bar_base | input | NWIN*ADDR_W | Window base addresses, packed |
| bar_mask | input | NWIN*ADDR_W | Window compare masks, packed |
| bar_en | input | NWIN | Window enables |
| local_uid | input | UID_W | This node's unit identifier |
| err_clr | input | 1 | Clears the sticky error flag |
| in_valid | input | 1 | Input beat valid |
| in_is_cmd | input | 1 | Beat is a command (1) or data (0) |
| in_ctype | input | 2 | Command class code |
| in_addr | input | ADDR_W | Request address |
| in_uid | input | UID_W | Unit identifier of the command |
| in_tag | input | TAG_W | Source tag of the command |
| in_dlen | input | LEN_W | Number of data beats that follow |
| in_data | input | DATA_W | Raw beat word |
| pq_wr | output | 1 | Posted queue write strobe |
| npq_wr | output | 1 | Non-posted queue write strobe |
| rq_wr | output | 1 | Response queue write strobe |
| q_is_cmd | output | 1 | Written word is a command |
| q_word | output | DATA_W | Word written to the selected queue |
| err_pulse | output | 1 | One-cycle error indication |
| err_sticky | output | 1 | Sticky error flag |
| nxa_valid | output | 1 | Non-existent-address response valid |
| nxa_uid | output | UID_W | Unit identifier for that response |
| nxa_tag | output | TAG_W | Source tag for that response |

## Verification
The assertions assume a well-formed input stream. Each command's data beats arrive before the next non-no-op command, and `in_dlen` is no larger than the data actually sent. The bench builds every packet as one command followed by exactly its declared beats, with random idle cycles and no-ops placed between them. Stray data beats are sent only when the bench's own model shows no beats outstanding, so they probe R9 without breaking the framing.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    typedef enum logic [1:0] {
        CT_NOP        = 2'b00,
        CT_POSTED     = 2'b01,
        CT_NONPOSTED  = 2'b10,
        CT_RESPONSE   = 2'b11
    } ctype_e;

    typedef enum logic [1:0] {
        RT_DROP = 2'b00,
        RT_PQ   = 2'b01,
        RT_NPQ  = 2'b10,
        RT_RQ   = 2'b11
    } route_e;
endpackage

// File: rtl/rxd_window_match.sv
module rxd_window_match #(
    parameter int NWIN   = 4,
    parameter int ADDR_W = 40
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [NWIN*ADDR_W-1:0] bar_base,
    input  logic [NWIN*ADDR_W-1:0] bar_mask,
    input  logic [NWIN-1:0]        bar_en,
    output logic                   hit
);
    logic [NWIN-1:0] win_hit;

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        logic [ADDR_W-1:0] msk;
        assign msk        = bar_mask[i*ADDR_W +: ADDR_W];
        assign win_hit[i] = bar_en[i] &&
                            ((addr & msk) == (bar_base[i*ADDR_W +: ADDR_W] & msk));
    end

    assign hit = |win_hit;
endmodule

// File: rtl/rxd_beat_tracker.sv
module rxd_beat_tracker
    import rxd_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_load,
    input  logic [LEN_W-1:0] load_len,
    input  route_e           load_route,
    input  logic             data_beat,
    output logic             active,
    output route_e           cur_route
);
    typedef struct packed {
        logic [LEN_W-1:0] rem;
        route_e           route;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_load) begin
            st_d.rem   = load_len;
            st_d.route = load_route;
        end else if (data_beat && st_q.rem != '0) begin
            st_d.rem = st_q.rem - LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{rem: '0, route: RT_DROP};
        end else begin
            st_q <= st_d;
        end
    end

    assign active    = (st_q.rem != '0);
    assign cur_route = st_q.route;

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (data_beat && !cmd_load && st_q.rem != '0) |=> (st_q.rem == $past(st_q.rem) - LEN_W'(1))) else $error("count"); // R6
    AST_ROUTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_load) |=> $stable(st_q.route)) else $error("route"); // R6
    AST_LOAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_load |=> (st_q.rem == $past(load_len))) else $error("load"); // R6
endmodule

// File: rtl/rxd_eoc_handler.sv
module rxd_eoc_handler #(
    parameter int UID_W = 5,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_evt,
    input  logic             err_clr,
    input  logic             nxa_evt,
    input  logic [UID_W-1:0] req_uid,
    input  logic [TAG_W-1:0] req_tag,
    output logic             err_pulse,
    output logic             err_sticky,
    output logic             nxa_valid,
    output logic [UID_W-1:0] nxa_uid,
    output logic [TAG_W-1:0] nxa_tag
);
    typedef struct packed {
        logic             pulse;
        logic             sticky;
        logic             nxa;
        logic [UID_W-1:0] uid;
        logic [TAG_W-1:0] tag;
    } eoc_t;

    eoc_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = err_evt;
        st_d.nxa   = nxa_evt;
        if (err_evt) begin
            st_d.sticky = 1'b1;
        end else if (err_clr) begin
            st_d.sticky = 1'b0;
        end
        if (nxa_evt) begin
            st_d.uid = req_uid;
            st_d.tag = req_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_pulse  = st_q.pulse;
    assign err_sticky = st_q.sticky;
    assign nxa_valid  = st_q.nxa;
    assign nxa_uid    = st_q.uid;
    assign nxa_tag    = st_q.tag;

    AST_PULSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> st_q.sticky) else $error("sticky"); // R7
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sticky && !err_clr) |=> st_q.sticky) else $error("hold"); // R7
    AST_NXA_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        nxa_evt |=> (st_q.nxa && st_q.tag == $past(req_tag) && st_q.uid == $past(req_uid))) else $error("nxa"); // R8
endmodule

// File: rtl/rxd_claim_dispatch.sv
module rxd_claim_dispatch
    import rxd_pkg::*;
#(
    parameter int NWIN   = 4,
    parameter int ADDR_W = 40,
    parameter int UID_W  = 5,
    parameter int TAG_W  = 5,
    parameter int LEN_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NWIN*ADDR_W-1:0] bar_base,
    input  logic [NWIN*ADDR_W-1:0] bar_mask,
    input  logic [NWIN-1:0]        bar_en,
    input  logic [UID_W-1:0]       local_uid,
    input  logic                   err_clr,
    input  logic                   in_valid,
    input  logic                   in_is_cmd,
    input  logic [1:0]             in_ctype,
    input  logic [ADDR_W-1:0]      in_addr,
    input  logic [UID_W-1:0]       in_uid,
    input  logic [TAG_W-1:0]       in_tag,
    input  logic [LEN_W-1:0]       in_dlen,
    input  logic [DATA_W-1:0]      in_data,
    output logic                   pq_wr,
    output logic                   npq_wr,
    output logic                   rq_wr,
    output logic                   q_is_cmd,
    output logic [DATA_W-1:0]      q_word,
    output logic                   err_pulse,
    output logic                   err_sticky,
    output logic                   nxa_valid,
    output logic [UID_W-1:0]       nxa_uid,
    output logic [TAG_W-1:0]       nxa_tag
);
    typedef struct packed {
        logic              pq;
        logic              npq;
        logic              rq;
        logic              is_cmd;
        logic [DATA_W-1:0] word;
    } qout_t;

    qout_t   out_d, out_q;
    ctype_e  ctype;
    logic    win_hit;
    logic    cmd_beat;
    logic    data_beat;
    logic    trk_active;
    route_e  trk_route;
    route_e  cmd_route;
    route_e  beat_route;
    logic    err_evt;
    logic    nxa_evt;

    rxd_window_match #(.NWIN(NWIN), .ADDR_W(ADDR_W)) u_win (
        .addr     (in_addr),
        .bar_base (bar_base),
        .bar_mask (bar_mask),
        .bar_en   (bar_en),
        .hit      (win_hit)
    );

    always_comb begin
        ctype     = ctype_e'(in_ctype);
        cmd_beat  = in_valid && in_is_cmd && (ctype != CT_NOP);
        data_beat = in_valid && !in_is_cmd;
        cmd_route = RT_DROP;
        unique case (ctype)
            CT_POSTED:    if (win_hit) cmd_route = RT_PQ;
            CT_NONPOSTED: if (win_hit) cmd_route = RT_NPQ;
            CT_RESPONSE:  if (in_uid == local_uid) cmd_route = RT_RQ;
            default:      cmd_route = RT_DROP;
        endcase
        if (cmd_beat) begin
            beat_route = cmd_route;
        end else if (data_beat && trk_active) begin
            beat_route = trk_route;
        end else begin
            beat_route = RT_DROP;
        end
        err_evt = cmd_beat && (cmd_route == RT_DROP) &&
                  (ctype == CT_POSTED || ctype == CT_RESPONSE);
        nxa_evt = cmd_beat && (cmd_route == RT_DROP) && (ctype == CT_NONPOSTED);
    end

    rxd_beat_tracker #(.LEN_W(LEN_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_load   (cmd_beat),
        .load_len   (in_dlen),
        .load_route (cmd_route),
        .data_beat  (data_beat),
        .active     (trk_active),
        .cur_route  (trk_route)
    );

    always_comb begin
        out_d        = out_q;
        out_d.pq     = (beat_route == RT_PQ);
        out_d.npq    = (beat_route == RT_NPQ);
        out_d.rq     = (beat_route == RT_RQ);
        out_d.is_cmd = in_is_cmd;
        if (beat_route != RT_DROP) begin
            out_d.word = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pq_wr    = out_q.pq;
    assign npq_wr   = out_q.npq;
    assign rq_wr    = out_q.rq;
    assign q_is_cmd = out_q.is_cmd;
    assign q_word   = out_q.word;

    rxd_eoc_handler #(.UID_W(UID_W), .TAG_W(TAG_W)) u_eoc (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_evt    (err_evt),
        .err_clr    (err_clr),
        .nxa_evt    (nxa_evt),
        .req_uid    (in_uid),
        .req_tag    (in_tag),
        .err_pulse  (err_pulse),
        .err_sticky (err_sticky),
        .nxa_valid  (nxa_valid),
        .nxa_uid    (nxa_uid),
        .nxa_tag    (nxa_tag)
    );

    AST_ONE_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pq_wr, npq_wr, rq_wr})) else $error("onehot"); // R4
    AST_NXA_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        nxa_valid |-> !(pq_wr || npq_wr || rq_wr || err_pulse)) else $error("nxa write"); // R8
    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> !(pq_wr || npq_wr || rq_wr)) else $error("err write"); // R7
    AST_STRAY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_beat && !trk_active) |=> !(pq_wr || npq_wr || rq_wr)) else $error("stray"); // R9
endmodule

// File: tb/rxd_claim_dispatch_bench.sv
module rxd_claim_dispatch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NWIN   = 4;
    localparam int ADDR_W = 40;
    localparam int UID_W  = 5;
    localparam int TAG_W  = 5;
    localparam int LEN_W  = 4;
    localparam int DATA_W = 32;
    localparam logic [UID_W-1:0] MY_UID = 5'h07;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NWIN*ADDR_W-1:0] bar_base, bar_mask;
    logic [NWIN-1:0] bar_en;
    logic err_clr = 1'b0, in_valid = 1'b0, in_is_cmd = 1'b0;
    logic [1:0] in_ctype = '0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [UID_W-1:0] in_uid = '0;
    logic [TAG_W-1:0] in_tag = '0;
    logic [LEN_W-1:0] in_dlen = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic pq_wr, npq_wr, rq_wr, q_is_cmd, err_pulse, err_sticky, nxa_valid;
    logic [DATA_W-1:0] q_word;
    logic [UID_W-1:0] nxa_uid;
    logic [TAG_W-1:0] nxa_tag;

    int n_checks = 0, n_errors = 0;
    int m_rem = 0, m_route = 0;
    logic m_sticky = 1'b0;
    logic [ADDR_W-1:0] wb [NWIN];
    logic [ADDR_W-1:0] wm [NWIN];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxd_claim_dispatch u_rxd_claim_dispatch (
        .clk(clk), .rst_n(rst_n), .bar_base(bar_base), .bar_mask(bar_mask),
        .bar_en(bar_en), .local_uid(MY_UID), .err_clr(err_clr),
        .in_valid(in_valid), .in_is_cmd(in_is_cmd), .in_ctype(in_ctype),
        .in_addr(in_addr), .in_uid(in_uid), .in_tag(in_tag), .in_dlen(in_dlen),
        .in_data(in_data), .pq_wr(pq_wr), .npq_wr(npq_wr), .rq_wr(rq_wr),
        .q_is_cmd(q_is_cmd), .q_word(q_word), .err_pulse(err_pulse),
        .err_sticky(err_sticky), .nxa_valid(nxa_valid), .nxa_uid(nxa_uid),
        .nxa_tag(nxa_tag)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit win_hit(logic [ADDR_W-1:0] a);
        for (int w = 0; w < NWIN; w++)
            if (bar_en[w] && ((a & wm[w]) == (wb[w] & wm[w]))) return 1'b1;
        return 1'b0;
    endfunction

    // route codes: 0 none, 1 posted queue, 2 non-posted queue, 3 response queue
    function automatic int cmd_route(logic [1:0] ct, logic [ADDR_W-1:0] a, logic [UID_W-1:0] u);
        if (ct == 2'b01 && win_hit(a)) return 1;
        if (ct == 2'b10 && win_hit(a)) return 2;
        if (ct == 2'b11 && u == MY_UID) return 3;
        return 0;
    endfunction

    task automatic beat(bit v, bit cmd, logic [1:0] ct, logic [ADDR_W-1:0] a,
                        logic [UID_W-1:0] u, logic [TAG_W-1:0] t,
                        logic [LEN_W-1:0] dl, logic [DATA_W-1:0] d, bit clr);
        int r = 0;
        bit e_err = 0, e_nxa = 0;
        if (v && cmd && ct != 2'b00) begin
            r = cmd_route(ct, a, u);
            e_err = (r == 0) && (ct == 2'b01 || ct == 2'b11);
            e_nxa = (r == 0) && (ct == 2'b10);
            m_rem = int'(dl);
            m_route = r;
        end else if (v && !cmd) begin
            if (m_rem > 0) begin
                r = m_route;
                m_rem--;
            end
        end
        if (e_err) m_sticky = 1'b1;
        else if (clr) m_sticky = 1'b0;
        @(negedge clk);
        in_valid = v; in_is_cmd = cmd; in_ctype = ct; in_addr = a; in_uid = u;
        in_tag = t; in_dlen = dl; in_data = d; err_clr = clr;
        @(posedge clk);
        #1;
        check("R4 pq_wr", 64'(pq_wr), 64'(r == 1));
        check("R4 npq_wr", 64'(npq_wr), 64'(r == 2));
        check("R5 rq_wr", 64'(rq_wr), 64'(r == 3));
        if (r != 0) begin
            check("R6 q_word", 64'(q_word), 64'(d));
            check("R6 q_is_cmd", 64'(q_is_cmd), 64'(cmd));
        end
        check("R7 err_pulse", 64'(err_pulse), 64'(e_err));
        check("R7 err_sticky", 64'(err_sticky), 64'(m_sticky));
        check("R8 nxa_valid", 64'(nxa_valid), 64'(e_nxa));
        if (e_nxa) begin
            check("R8 nxa_tag", 64'(nxa_tag), 64'(t));
            check("R8 nxa_uid", 64'(nxa_uid), 64'(u));
        end
    endtask

    task automatic idle(bit clr);
        beat(0, 0, 2'b00, '0, '0, '0, '0, '0, clr);
    endtask

    task automatic packet(logic [1:0] ct, logic [ADDR_W-1:0] a, logic [UID_W-1:0] u,
                          logic [TAG_W-1:0] t, logic [LEN_W-1:0] dl);
        beat(1, 1, ct, a, u, t, dl, $urandom, 0);
        for (int i = 0; i < int'(dl); i++) beat(1, 0, 2'b00, '0, '0, '0, '0, $urandom, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        wb[0] = 40'h00_1000_0000; wm[0] = 40'hFF_F000_0000;
        wb[1] = 40'h80_0000_0000; wm[1] = 40'hFF_FFFF_F000;
        wb[2] = 40'h12_3400_0000; wm[2] = 40'hFF_FF00_0000;
        wb[3] = 40'h20_0000_0000; wm[3] = 40'hFF_0000_0000;
        for (int w = 0; w < NWIN; w++) begin
            bar_base[w*ADDR_W +: ADDR_W] = wb[w];
            bar_mask[w*ADDR_W +: ADDR_W] = wm[w];
        end
        bar_en = 4'b0111;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset strobes", 64'({pq_wr, npq_wr, rq_wr}), 64'd0);
        check("R1 reset err", 64'({err_pulse, err_sticky, nxa_valid}), 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after reset", 64'({pq_wr, npq_wr, rq_wr, err_pulse, err_sticky, nxa_valid}), 64'd0);

        // R3 window boundaries
        packet(2'b01, 40'h80_0000_0000, 5'h01, 5'h03, 4'd1);
        packet(2'b01, 40'h80_0000_0FFF, 5'h01, 5'h04, 4'd0);
        packet(2'b10, 40'h80_0000_1000, 5'h09, 5'h15, 4'd2);    // R8 miss just above window
        packet(2'b10, 40'h20_0000_0040, 5'h02, 5'h1A, 4'd0);    // R3 disabled window
        packet(2'b10, 40'h12_34AB_CDE0, 5'h02, 5'h0B, 4'd3);    // R4 non-posted claim
        // R5 response match / mismatch
        packet(2'b11, '0, MY_UID, 5'h01, 4'd2);
        packet(2'b11, '0, 5'h08, 5'h01, 4'd1);                   // R7 sets sticky
        idle(0);
        idle(1);                                                 // R7 clear
        // R7 clear and new error in the same cycle: error wins
        beat(1, 1, 2'b01, 40'h55_0000_0000, 5'h0, 5'h0, 4'd0, 32'h1, 1);
        idle(1);
        // R2 / R6 no-op and idle between command and its data
        beat(1, 1, 2'b01, 40'h00_1234_5678, 5'h0, 5'h0, 4'd2, 32'hA0, 0);
        beat(1, 1, 2'b00, 40'h00_1234_5678, 5'h0, 5'h0, 4'd0, 32'hA1, 0);
        idle(0);
        beat(1, 0, 2'b00, '0, '0, '0, '0, 32'hA2, 0);
        beat(1, 1, 2'b00, 40'h55_0000_0000, 5'h0, 5'h0, 4'd5, 32'hA3, 0);
        beat(1, 0, 2'b00, '0, '0, '0, '0, 32'hA4, 0);
        // R9 stray data beat with nothing outstanding
        beat(1, 0, 2'b00, '0, '0, '0, '0, 32'hDEAD, 0);

        for (int p = 0; p < 600; p++) begin
            logic [ADDR_W-1:0] a;
            logic [1:0] ct;
            logic [UID_W-1:0] u;
            int sel = int'($urandom % 5);
            case (sel)
                0: a = wb[0] | ADDR_W'($urandom & 32'h0FFF_FFFF);
                1: a = wb[1] | ADDR_W'($urandom & 32'h0000_0FFF);
                2: a = wb[2] | ADDR_W'($urandom & 32'h00FF_FFFF);
                3: a = wb[3] | ADDR_W'($urandom & 32'h00FF_FFFF);
                default: a = {8'($urandom), 32'($urandom)};
            endcase
            ct = 2'($urandom % 3 + 1);
            u = ($urandom % 2 == 0) ? MY_UID : 5'($urandom);
            packet(ct, a, u, 5'($urandom), 4'($urandom % 4));
            if ($urandom % 4 == 0) idle(($urandom % 3) == 0);
            if ($urandom % 10 == 0) beat(1, 0, 2'b00, '0, '0, '0, '0, $urandom, 0); // R9
            if ($urandom % 10 == 0) beat(1, 1, 2'b00, a, u, '0, 4'd3, $urandom, 0); // R2
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule